// File: doc/BRIEF.md
# Entropy Bit Collector

A memory-mapped collector of random bits. A single external entropy input, standing in for a free-running oscillator, is captured once every programmable number of clocks. The captured bits are packed into an output buffer of 64, 128, 192 or 256 bits, which software reads as eight 32-bit words. Software sets a start bit to launch a collection and polls that bit until the hardware clears it.

The control register takes a write mask in its upper halfword, so software can change individual fields without a read-modify-write. The block also holds an oscillator speed setting and drives it to an output port. A write to a dedicated offset clears the control state, the collection counters and the output words.

Top module: `entropy_sampler`

## Requirements
- R1: A write to the control register (0x400) changes bit i of [15:0] only when bit 16+i of the write word is 1. Every other control bit keeps its value. A read returns the stored 16 bits in [15:0] and zero above.
- R2: Control bit 0 is START and bit 1 is ENABLE. Bits [5:4] hold a code L, and the collection length is 64*(L+1) bits. With ENABLE=1, writing START=1 gathers that many bits. START then reads 0 from clock edge 1+N*P after the write edge, where N is the bit count and P is the capture period. The other control bits keep their values.
- R3: The register at 0x404 (low 16 bits, readable) sets the capture period P in clocks. A value of 0 acts as 1. Capture k (counted from 0) takes the input present before edge 1+(k+1)*P after the start write.
- R4: Capture k is stored in word k/32 (word 0 at 0x410, one word every 4 bytes up to 0x42C), at bit 31-(k mod 32). The first bit captured is therefore the MSB of word 0.
- R5: Starting a collection clears all eight output words. Words beyond the selected length read zero.
- R6: If START is 1 while ENABLE is 0, START reads 0 one clock later. No capture takes place and the output words are unchanged.
- R7: Any write to 0x004 clears the control register, the collection state and all output words. The period register keeps its value.
- R8: Writing 0xFFFF0000 to 0x400 stops a collection in progress. After that the output words no longer change, and START and the speed output read 0.
- R9: The output osc_speed always equals control bits [3:2].
- R10: A read from an unmapped or unaligned offset returns 0. Writes to output words and to unmapped offsets change nothing that can be read.
- R11: After reset the control register, the period register, all output words and osc_speed are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| entropy_in | input | 1 | Entropy bit, synchronous to clk |
| osc_speed | output | 2 | Oscillator speed setting from the control register |

## Verification
The assertions assume that entropy_in and the bus inputs are already synchronous to clk. They also assume that software changes the length and enable fields during a collection only to stop it. The stimulus changes every input only at the falling edge of the clock. It rewrites the control register only between collections, or with the full stop word or a START-without-ENABLE word. The length is latched when a collection starts, so the bit-count bound holds even if the length field is rewritten later.

// File: rtl/es_pkg.sv
package es_pkg;
  localparam int unsigned OFF_SRST = 12'h004;
  localparam int unsigned OFF_CTRL = 12'h400;
  localparam int unsigned OFF_SCNT = 12'h404;
  localparam int unsigned OFF_OUT0 = 12'h410;
  localparam int unsigned CB_START = 0;
  localparam int unsigned CB_EN    = 1;
  localparam int unsigned CB_SPD   = 2;
  localparam int unsigned CB_LEN   = 4;
endpackage

// File: rtl/es_ctrl_reg.sv
module es_ctrl_reg
  import es_pkg::*;
#(
  parameter int unsigned CTRL_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  soft_rst,
  input  logic                  wr_en,
  input  logic [2*CTRL_W-1:0]   wr_word,
  input  logic                  hw_clr_start,
  output logic [CTRL_W-1:0]     ctrl_q
);
  logic [CTRL_W-1:0] wmask, wval, ctrl_d;
  logic              upd;

  assign wmask = wr_word[2*CTRL_W-1:CTRL_W];
  assign wval  = wr_word[CTRL_W-1:0];
  assign upd   = soft_rst | wr_en | hw_clr_start;

  always_comb begin
    ctrl_d = ctrl_q;
    if (hw_clr_start) ctrl_d[CB_START] = 1'b0;
    if (wr_en)        ctrl_d = (ctrl_d & ~wmask) | (wval & wmask);
    if (soft_rst)     ctrl_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ctrl_q <= '0;
    else if (upd) ctrl_q <= ctrl_d;
  end

  // R1: unmasked bits (START excluded, hardware may clear it) hold
  a_r1_masked_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !soft_rst) |=>
      ((ctrl_q[CTRL_W-1:1] & ~$past(wmask[CTRL_W-1:1])) ==
       ($past(ctrl_q[CTRL_W-1:1]) & ~$past(wmask[CTRL_W-1:1]))));

  // R6: START without ENABLE drops on the next clock
  a_r6_start_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CB_START] && !ctrl_q[CB_EN] && !wr_en && !soft_rst) |=> !ctrl_q[CB_START]);

  // R7: soft reset clears the control register
  a_r7_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ctrl_q == '0));
endmodule

// File: rtl/es_sampler.sv
module es_sampler #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned NBITS = 256,
  parameter int unsigned BIT_W = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             start,
  input  logic             enable,
  input  logic [1:0]       len_code,
  input  logic [CNT_W-1:0] period,
  output logic             busy_q,
  output logic             go,
  output logic             cap_en,
  output logic [BIT_W-1:0] cap_idx,
  output logic             done
);
  localparam int unsigned STEP = NBITS / 4;

  logic [CNT_W-1:0] pcnt_q, pcnt_d, last_cnt;
  logic [BIT_W-1:0] bcnt_q, bcnt_d;
  logic [BIT_W:0]   nbits_q, nbits_d, nbits_sel;
  logic             busy_d, tick, last, upd;

  assign nbits_sel = ((BIT_W+1)'(len_code) + (BIT_W+1)'(1)) * (BIT_W+1)'(STEP);
  assign last_cnt  = (period == '0) ? '0 : period - CNT_W'(1);
  assign tick      = (pcnt_q >= last_cnt);
  assign last      = ({1'b0, bcnt_q} == nbits_q - (BIT_W+1)'(1));
  assign go        = start & enable & ~busy_q & ~soft_rst;
  assign cap_en    = busy_q & enable & tick & ~soft_rst;
  assign done      = cap_en & last;
  assign cap_idx   = bcnt_q;
  assign upd       = soft_rst | go | busy_q;

  always_comb begin
    busy_d  = busy_q;
    pcnt_d  = pcnt_q;
    bcnt_d  = bcnt_q;
    nbits_d = nbits_q;
    if (soft_rst) begin
      busy_d = 1'b0;
      pcnt_d = '0;
      bcnt_d = '0;
    end else if (go) begin
      busy_d  = 1'b1;
      pcnt_d  = '0;
      bcnt_d  = '0;
      nbits_d = nbits_sel;
    end else if (busy_q) begin
      if (!enable) begin
        busy_d = 1'b0;
      end else if (tick) begin
        pcnt_d = '0;
        bcnt_d = bcnt_q + BIT_W'(1);
        if (last) busy_d = 1'b0;
      end else begin
        pcnt_d = pcnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      pcnt_q  <= '0;
      bcnt_q  <= '0;
      nbits_q <= '0;
    end else if (upd) begin
      busy_q  <= busy_d;
      pcnt_q  <= pcnt_d;
      bcnt_q  <= bcnt_d;
      nbits_q <= nbits_d;
    end
  end

  // R2: bit counter never reaches the latched length while busy
  a_r2_bits_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ({1'b0, bcnt_q} < nbits_q));

  // R2: the final capture ends the collection
  a_r2_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);
endmodule

// File: rtl/es_outbuf.sv
module es_outbuf #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned N_WORDS = 8,
  parameter int unsigned BIT_W   = $clog2(WORD_W * N_WORDS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             soft_rst,
  input  logic                             clear,
  input  logic                             cap_en,
  input  logic [BIT_W-1:0]                 cap_idx,
  input  logic                             bit_in,
  output logic [N_WORDS-1:0][WORD_W-1:0]   words_q
);
  localparam int unsigned BW = $clog2(WORD_W);

  logic [N_WORDS-1:0][WORD_W-1:0] words_d;
  logic                           upd;

  assign upd = soft_rst | clear | cap_en;

  always_comb begin
    words_d = words_q;
    if (soft_rst || clear)
      words_d = '0;
    else if (cap_en)
      words_d[cap_idx[BIT_W-1:BW]][~cap_idx[BW-1:0]] = bit_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   words_q <= '0;
    else if (upd) words_q <= words_d;
  end

  // R5: a new collection starts from an all-zero buffer
  a_r5_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (words_q == '0));

  // R4: one capture changes at most one stored bit
  a_r4_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !soft_rst && !clear) |=> ($countones(words_q ^ $past(words_q)) <= 1));
endmodule

// File: rtl/entropy_sampler.sv
module entropy_sampler
  import es_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned N_WORDS = 8,
  parameter int unsigned CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              entropy_in,
  output logic [1:0]        osc_speed
);
  localparam int unsigned CTRL_W = WORD_W / 2;
  localparam int unsigned NBITS  = WORD_W * N_WORDS;
  localparam int unsigned BIT_W  = $clog2(NBITS);
  localparam int unsigned IDX_W  = $clog2(N_WORDS);

  logic [1:0]                      rs_q;
  logic                            rst_ni;
  logic                            wr_ctrl, wr_scnt, soft_rst, hw_clr;
  logic [CTRL_W-1:0]               ctrl_q;
  logic [CNT_W-1:0]                scnt_q;
  logic                            busy, go, cap_en, done;
  logic [BIT_W-1:0]                cap_idx;
  logic [N_WORDS-1:0][WORD_W-1:0]  words;
  logic [ADDR_W-1:0]               out_off;
  logic                            out_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  assign wr_ctrl  = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_scnt  = bus_we && (bus_addr == ADDR_W'(OFF_SCNT));
  assign soft_rst = bus_we && (bus_addr == ADDR_W'(OFF_SRST));
  assign hw_clr   = done | (ctrl_q[CB_START] & ~ctrl_q[CB_EN]);

  es_ctrl_reg #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_ni), .soft_rst(soft_rst), .wr_en(wr_ctrl),
    .wr_word(bus_wdata), .hw_clr_start(hw_clr), .ctrl_q(ctrl_q)
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      scnt_q <= '0;
    else if (wr_scnt) scnt_q <= bus_wdata[CNT_W-1:0];
  end

  es_sampler #(.CNT_W(CNT_W), .NBITS(NBITS), .BIT_W(BIT_W)) u_smp (
    .clk(clk), .rst_n(rst_ni), .soft_rst(soft_rst),
    .start(ctrl_q[CB_START]), .enable(ctrl_q[CB_EN]),
    .len_code(ctrl_q[CB_LEN+1:CB_LEN]), .period(scnt_q),
    .busy_q(busy), .go(go), .cap_en(cap_en), .cap_idx(cap_idx), .done(done)
  );

  es_outbuf #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .BIT_W(BIT_W)) u_buf (
    .clk(clk), .rst_n(rst_ni), .soft_rst(soft_rst), .clear(go),
    .cap_en(cap_en), .cap_idx(cap_idx), .bit_in(entropy_in), .words_q(words)
  );

  assign osc_speed = ctrl_q[CB_SPD+1:CB_SPD];

  assign out_off = bus_addr - ADDR_W'(OFF_OUT0);
  assign out_hit = (out_off < ADDR_W'(4 * N_WORDS)) && (out_off[1:0] == 2'b00);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_CTRL))      bus_rdata = {{(WORD_W-CTRL_W){1'b0}}, ctrl_q};
    else if (bus_addr == ADDR_W'(OFF_SCNT)) bus_rdata = {{(WORD_W-CNT_W){1'b0}}, scnt_q};
    else if (out_hit)                       bus_rdata = words[out_off[IDX_W+1:2]];
  end

  // R9: speed output tracks the control field
  a_r9_speed_port: assert property (@(posedge clk) disable iff (!rst_ni)
    osc_speed == ctrl_q[CB_SPD+1:CB_SPD]);

  // R2: while collecting, START stays set unless software stops it
  a_r2_start_held: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && !done && !wr_ctrl && !soft_rst && ctrl_q[CB_EN]) |=> ctrl_q[CB_START]);
endmodule

// File: tb/tb_entropy_sampler.sv
module tb_entropy_sampler;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] addr;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        ent;
  logic [1:0]  spd;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  entropy_sampler dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .entropy_in(ent), .osc_speed(spd)
  );

  // {len nibble, speed nibble, period byte, seed byte}
  localparam logic [23:0] VEC [5] = '{
    24'h31035A, 24'h020113, 24'h1300C7, 24'h20022E, 24'h320491
  };

  function automatic logic pat(input int k, input logic [7:0] s);
    logic [15:0] h;
    h = 16'(k * 29) + {8'd0, s};
    return h[3] ^ h[6] ^ h[9];
  endfunction

  function automatic logic [31:0] exp_word(input logic [23:0] v, input int w);
    logic [31:0] e;
    int nb;
    nb = 64 * (int'(v[21:20]) + 1);
    e = '0;
    for (int b = 0; b < 32; b++)
      if (32 * w + b < nb) e[31-b] = pat(32 * w + b, v[7:0]);
    return e;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    #1;
    we = 1'b0; addr = 12'hFFC;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1;
    d = rdata;
  endtask

  task automatic run_vec(input logic [23:0] v);
    int len, sp, per, pe, nb, m, done_m;
    logic [31:0] got;
    len = int'(v[21:20]); sp = int'(v[17:16]); per = int'(v[15:8]);
    pe = (per == 0) ? 1 : per;
    nb = 64 * (len + 1);
    m = 0; done_m = -1;
    bus_write(12'h404, 32'(per));
    bus_write(12'h400, 32'h003F_0000 | 32'(len << 4) | 32'(sp << 2) | 32'h3);
    forever begin
      @(negedge clk);
      ent = (m >= 1) ? pat((m - 1) / pe, v[7:0]) : 1'b0;
      addr = 12'h400;
      #1;
      if (rdata[0] == 1'b0) begin done_m = m; break; end
      if (m > 4000) break;
      @(posedge clk);
      m++;
    end
    check("R2/R3 completion cycle", 32'(done_m), 32'(1 + nb * pe));
    for (int w = 0; w < 8; w++) begin
      bus_read(12'h410 + 12'(4 * w), got);
      check((32 * w < nb) ? "R4 packed word" : "R5 zero beyond length", got, exp_word(v, w));
    end
    bus_read(12'h400, got);
    check("R2 control after done", got, 32'(len << 4) | 32'(sp << 2) | 32'h2);
    check("R9 speed port", 32'(spd), 32'(sp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got running expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] got;
    logic [31:0] snap [8];
    rst_n = 1'b0; we = 1'b0; addr = 12'hFFC; wdata = '0; ent = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R11: reset state
    bus_read(12'h400, got); check("R11 control reset", got, 32'h0);
    bus_read(12'h404, got); check("R11 period reset", got, 32'h0);
    for (int w = 0; w < 8; w++) begin
      bus_read(12'h410 + 12'(4 * w), got); check("R11 word reset", got, 32'h0);
    end
    check("R11 speed reset", 32'(spd), 32'h0);

    // R1: masked writes
    bus_write(12'h400, 32'h000C_003C);
    bus_read(12'h400, got); check("R1 masked set", got, 32'h000C);
    check("R9 speed 3", 32'(spd), 32'h3);
    bus_write(12'h400, 32'h0000_FFFF);
    bus_read(12'h400, got); check("R1 empty mask", got, 32'h000C);
    bus_write(12'h400, 32'h8004_8000);
    bus_read(12'h400, got); check("R1 partial mask", got, 32'h8008);
    check("R9 speed 2", 32'(spd), 32'h2);
    bus_write(12'h400, 32'hFFFF_0000);
    bus_read(12'h400, got); check("R1 full clear", got, 32'h0);

    // R2..R5: vector table
    for (int i = 0; i < 5; i++) run_vec(VEC[i]);

    // R6: START while ENABLE is 0
    bus_write(12'h400, 32'h0003_0001);
    bus_read(12'h400, got); check("R6 start latched", got, 32'h0039);
    bus_read(12'h400, got); check("R6 start dropped", got, 32'h0038);
    repeat (20) @(posedge clk);
    for (int w = 0; w < 8; w++) begin
      bus_read(12'h410 + 12'(4 * w), got); check("R6 words unchanged", got, exp_word(VEC[4], w));
    end

    // R7: soft reset
    bus_write(12'h404, 32'd9);
    bus_write(12'h004, 32'h0);
    bus_read(12'h400, got); check("R7 control cleared", got, 32'h0);
    check("R7 speed cleared", 32'(spd), 32'h0);
    bus_read(12'h404, got); check("R7 period kept", got, 32'd9);
    for (int w = 0; w < 8; w++) begin
      bus_read(12'h410 + 12'(4 * w), got); check("R7 word cleared", got, 32'h0);
    end

    // R8: stop in progress
    bus_write(12'h404, 32'd5);
    bus_write(12'h400, 32'h003F_0033);
    repeat (40) @(posedge clk);
    bus_write(12'h400, 32'hFFFF_0000);
    bus_read(12'h400, got); check("R8 control stopped", got, 32'h0);
    check("R8 speed stopped", 32'(spd), 32'h0);
    for (int w = 0; w < 8; w++) bus_read(12'h410 + 12'(4 * w), snap[w]);
    ent = 1'b1;
    repeat (1500) @(posedge clk);
    for (int w = 0; w < 8; w++) begin
      bus_read(12'h410 + 12'(4 * w), got); check("R8 words frozen", got, snap[w]);
    end
    bus_read(12'h400, got); check("R8 still idle", got, 32'h0);

    // R10: unmapped and read-only
    bus_read(12'h000, got); check("R10 unmapped 0x000", got, 32'h0);
    bus_read(12'h408, got); check("R10 unmapped 0x408", got, 32'h0);
    bus_read(12'h430, got); check("R10 unmapped 0x430", got, 32'h0);
    bus_read(12'h412, got); check("R10 unaligned 0x412", got, 32'h0);
    bus_write(12'h410, 32'hFFFF_FFFF);
    bus_read(12'h410, got); check("R10 output read-only", got, snap[0]);
    bus_write(12'h408, 32'hFFFF_FFFF);
    bus_read(12'h408, got); check("R10 unmapped write", got, 32'h0);
    bus_read(12'h400, got); check("R10 control untouched", got, 32'h0);

    finish_run();
  end
endmodule